// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer with Half-Way Signalling

This block sequences one DMA channel through a programmed number of transfer pairs. Each pair is a read phase followed by a write phase. A small external bus model completes each phase by pulsing a done input. The block counts the remaining pairs down and stops when the count reaches zero. In reload mode it instead restores the programmed count and carries on.

A status flag rises at the midpoint of the job. The midpoint is taken on the completion of a read phase, when the remaining count has dropped to half of the count programmed at start, rounded down. That flag, together with an enable bit, requests a CPU interrupt. In reload mode the flag and the interrupt are suppressed.

The block also drives a device acknowledge strobe. Software selects whether the strobe covers the read phase or the write phase, and whether it is active high or active low.

Software uses a simple write port with three targets:
- `reg_sel`=0 loads the transfer count.
- `reg_sel`=1 writes the control bits.
- `reg_sel`=2 clears flags by writing ones.

Top module: `dma_half_seq`

## Requirements
- R1: A control write (`reg_sel`=1) with bit 0 (enable) set, made while the channel is idle and the count is nonzero, starts a job: `busy` and `rd_req` go high on the next cycle. Control bits: 1 reload, 2 half-way interrupt enable, 3 strobe phase, 4 strobe polarity.
- R2: `rd_req` and `wr_req` are never high together. A `rd_done` pulse during the read phase moves the block to the write phase and decrements `count` by one. A `wr_done` pulse during the write phase moves it back to the read phase while `count` is nonzero.
- R3: Outside reload mode, `half_flag` sets on the read completion that leaves `count` equal to the start count shifted right by one (count 1 gives 0; count 7 gives 3). It never sets in reload mode.
- R4: `irq` is high exactly when `half_flag` is 1, the enable bit (control bit 2) is 1, and reload mode is off.
- R5: On the write completion with `count` at zero, `end_flag` sets. Outside reload mode the channel then goes idle. In reload mode `count` is restored to its start value and the job continues.
- R6: With control bit 3 at 0 the strobe is active during the read phase. With control bit 3 at 1 it is active during the write phase.
- R7: With control bit 4 at 0 the strobe is active low; with bit 4 at 1 it is active high. Whenever the channel is idle, including after a control write with bit 0 at 0 aborts a job, the strobe sits at its inactive level.
- R8: A write to `reg_sel`=2 clears `half_flag` where bit 0 is 1 and `end_flag` where bit 1 is 1. Starting a job clears both flags.
- R9: Count writes (`reg_sel`=0) are ignored while a job runs. An enable write with a count of zero does not start a job.
- R10: After reset all control bits, flags and the count are 0, the channel is idle, `irq` is low, and the strobe is high (inactive, active-low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Write target: 0 count, 1 control, 2 flag clear |
| reg_wdata | input | CW | Write data |
| rd_req | output | 1 | Read phase in progress |
| rd_done | input | 1 | Read phase completed by the bus |
| wr_req | output | 1 | Write phase in progress |
| wr_done | input | 1 | Write phase completed by the bus |
| ack | output | 1 | Device acknowledge strobe |
| irq | output | 1 | Half-way interrupt request |
| busy | output | 1 | Job running |
| half_flag | output | 1 | Half-way status flag |
| end_flag | output | 1 | Transfer end status flag |
| count | output | CW | Remaining transfer count |

## Verification
On every cycle, the assertions check four things:
- the read and write phases never overlap;
- the half-way flag rises only out of a read completion and never in reload mode;
- a non-reload end leaves the channel idle;
- a fresh start has both flags clear, and the strobe rests at its inactive level while idle.

The bench's scenarios are what show the rest:
- the flag lands on exactly the floored midpoint for counts 1, 2, 7 and 16;
- the interrupt follows its enable;
- the strobe is correct in all four phase and polarity settings;
- reload continues without any flag;
- count writes are ignored while a job runs.

// File: rtl/dma_half_seq.sv
module dma_half_seq #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [1:0]    reg_sel,
  input  logic [CW-1:0] reg_wdata,
  output logic          rd_req,
  input  logic          rd_done,
  output logic          wr_req,
  input  logic          wr_done,
  output logic          ack,
  output logic          irq,
  output logic          busy,
  output logic          half_flag,
  output logic          end_flag,
  output logic [CW-1:0] count
);

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR} st_t;

  st_t           st;
  logic [CW-1:0] cnt_q, init_q, half_q;
  logic          reload_q, hie_q, amode_q, alev_q;
  logic          half_q_flag, end_q_flag;

  wire wr_cnt  = reg_we && reg_sel == 2'd0;
  wire wr_ctl  = reg_we && reg_sel == 2'd1;
  wire wr_clr  = reg_we && reg_sel == 2'd2;
  wire start   = wr_ctl && reg_wdata[0] && st == S_IDLE && cnt_q != '0;
  wire stop    = wr_ctl && !reg_wdata[0] && st != S_IDLE;
  wire rd_fire = st == S_RD && rd_done;
  wire wr_fire = st == S_WR && wr_done;
  wire [CW-1:0] cnt_dec = cnt_q - 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      cnt_q       <= '0;
      init_q      <= '0;
      half_q      <= '0;
      reload_q    <= 1'b0;
      hie_q       <= 1'b0;
      amode_q     <= 1'b0;
      alev_q      <= 1'b0;
      half_q_flag <= 1'b0;
      end_q_flag  <= 1'b0;
    end else begin
      if (wr_ctl) begin
        reload_q <= reg_wdata[1];
        hie_q    <= reg_wdata[2];
        amode_q  <= reg_wdata[3];
        alev_q   <= reg_wdata[4];
      end
      if (wr_cnt && st == S_IDLE) cnt_q <= reg_wdata;
      if (wr_clr && reg_wdata[0]) half_q_flag <= 1'b0;
      if (wr_clr && reg_wdata[1]) end_q_flag  <= 1'b0;
      if (start) begin
        init_q      <= cnt_q;
        half_q      <= cnt_q >> 1;
        half_q_flag <= 1'b0;
        end_q_flag  <= 1'b0;
        st          <= S_RD;
      end else if (stop) begin
        st <= S_IDLE;
      end else if (rd_fire) begin
        cnt_q <= cnt_dec;
        st    <= S_WR;
        if (!reload_q && cnt_dec == half_q) half_q_flag <= 1'b1;
      end else if (wr_fire) begin
        if (cnt_q == '0) begin
          end_q_flag <= 1'b1;
          if (reload_q) begin
            cnt_q <= init_q;
            st    <= S_RD;
          end else begin
            st <= S_IDLE;
          end
        end else begin
          st <= S_RD;
        end
      end
    end
  end

  wire strobe_on = amode_q ? (st == S_WR) : (st == S_RD);

  assign rd_req    = st == S_RD;
  assign wr_req    = st == S_WR;
  assign busy      = st != S_IDLE;
  assign ack       = alev_q ? strobe_on : !strobe_on;
  assign irq       = half_q_flag && hie_q && !reload_q;
  assign half_flag = half_q_flag;
  assign end_flag  = end_q_flag;
  assign count     = cnt_q;

endmodule

// File: rtl/dma_half_seq_chk.sv
module dma_half_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic rd_req,
  input logic rd_done,
  input logic wr_req,
  input logic busy,
  input logic ack,
  input logic half_flag,
  input logic end_flag,
  input logic reload_q,
  input logic alev_q
);

  AST_RW_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req && wr_req)); // R2

  AST_HALF_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(half_flag) |-> $past(rd_req && rd_done)); // R3

  AST_HALF_NOT_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(half_flag) |-> !$past(reload_q)); // R3

  AST_END_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(end_flag) && !$past(reload_q)) |-> !busy); // R5

  AST_ACK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (ack == !alev_q)); // R7

  AST_START_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (!half_flag && !end_flag)); // R8

endmodule

bind dma_half_seq dma_half_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_done(rd_done),
  .wr_req(wr_req), .busy(busy), .ack(ack), .half_flag(half_flag),
  .end_flag(end_flag), .reload_q(reload_q), .alev_q(alev_q)
);

// File: tb/dma_half_seq_test.sv
module dma_half_seq_test;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [1:0] reg_sel = '0;
  logic [CW-1:0] reg_wdata = '0;
  logic rd_done = 1'b0, wr_done = 1'b0;
  logic rd_req, wr_req, ack, irq, busy, half_flag, end_flag;
  logic [CW-1:0] count;

  always #2.5 clk = ~clk;

  dma_half_seq #(.CW(CW)) uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .rd_req(rd_req), .rd_done(rd_done),
    .wr_req(wr_req), .wr_done(wr_done), .ack(ack), .irq(irq),
    .busy(busy), .half_flag(half_flag), .end_flag(end_flag), .count(count)
  );

  int checks = 0, errors = 0, cycles = 0;
  logic stub_on = 1'b1, mon_on = 1'b0, m_mode = 1'b0, m_lvl = 1'b0;
  logic half_seen = 1'b0, half_in_wr = 1'b0;
  int half_cnt = 0, ack_err = 0, ack_seen = 0;

  // {count[7:0], hie, phase, polarity}
  localparam logic [10:0] VEC [8] = '{
    {8'd1, 1'b1, 1'b0, 1'b0}, {8'd2, 1'b1, 1'b0, 1'b1},
    {8'd7, 1'b1, 1'b1, 1'b0}, {8'd16, 1'b1, 1'b1, 1'b1},
    {8'd16, 1'b0, 1'b0, 1'b0}, {8'd7, 1'b0, 1'b0, 1'b1},
    {8'd2, 1'b0, 1'b1, 1'b0}, {8'd1, 1'b0, 1'b1, 1'b1}
  };

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cycles);
      summary();
    end
  end

  always @(negedge clk) begin
    if (mon_on) begin
      logic act, exp_ack;
      act = m_mode ? wr_req : rd_req;
      exp_ack = m_lvl ? act : !act;
      if (ack !== exp_ack) ack_err++;
      if (act) ack_seen++;
      if (half_flag && busy && !half_seen) begin
        half_seen = 1'b1; half_cnt = int'(count); half_in_wr = wr_req;
      end
    end
    rd_done <= stub_on && rd_req;
    wr_done <= stub_on && wr_req;
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic reg_wr(logic [1:0] sel, logic [CW-1:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic wait_end();
    for (int i = 0; i < 500 && !end_flag; i++) @(negedge clk);
  endtask

  task automatic run_job(int n, logic hie, logic md, logic lv);
    m_mode = md; m_lvl = lv;
    reg_wr(2'd0, CW'(n));
    reg_wr(2'd1, CW'({lv, md, hie, 1'b0, 1'b0}));
    half_seen = 1'b0; ack_err = 0; ack_seen = 0;
    mon_on = 1'b1;
    reg_wr(2'd1, CW'({lv, md, hie, 1'b0, 1'b1}));
    wait_end();
    @(negedge clk);
    mon_on = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 ack idle high", ack, 1);
    chk("R10 irq", irq, 0);
    chk("R10 busy", busy, 0);
    chk("R10 flags", {half_flag, end_flag}, 0);
    chk("R10 count", count, 0);

    foreach (VEC[v]) begin
      int n;
      n = int'(VEC[v][10:3]);
      run_job(n, VEC[v][2], VEC[v][1], VEC[v][0]);
      chk("R5 end flag", end_flag, 1);
      chk("R5 idle after end", busy, 0);
      chk("R2 count at zero", count, 0);
      chk("R3 half flag set", half_flag, 1);
      chk("R3 count at half", half_cnt, n >> 1);
      chk("R3 set on read completion", half_in_wr, 1);
      chk("R4 irq follows enable", irq, VEC[v][2]);
      chk("R6 strobe phase seen", ack_seen, n);
      chk("R7 strobe level", ack_err, 0);
    end

    // R9 and R8: stalled job, count write ignored, start clears flags
    stub_on = 1'b0;
    reg_wr(2'd0, 16);
    reg_wr(2'd1, 1);
    chk("R1 busy after start", busy, 1);
    chk("R1 read phase", rd_req, 1);
    chk("R8 start clears half", half_flag, 0);
    chk("R8 start clears end", end_flag, 0);
    chk("R6 active-low in read", ack, 0);
    reg_wr(2'd0, 5);
    chk("R9 count write ignored", count, 16);
    reg_wr(2'd1, 0);
    chk("R7 abort idle", busy, 0);
    chk("R7 abort strobe inactive", ack, 1);
    reg_wr(2'd0, 0);
    reg_wr(2'd1, 1);
    chk("R9 zero count no start", busy, 0);
    stub_on = 1'b1;

    // R8 write-one-to-clear
    run_job(2, 1'b1, 1'b0, 1'b0);
    chk("R4 irq before clear", irq, 1);
    reg_wr(2'd2, 1);
    chk("R8 half cleared", half_flag, 0);
    chk("R8 end kept", end_flag, 1);
    chk("R4 irq after clear", irq, 0);
    reg_wr(2'd2, 2);
    chk("R8 end cleared", end_flag, 0);

    // R3/R4/R5 reload mode: continues, no half flag or irq
    reg_wr(2'd0, 4);
    reg_wr(2'd1, CW'(5'b10111));
    wait_end();
    chk("R5 reload end flag", end_flag, 1);
    repeat (11) @(negedge clk);
    chk("R5 reload continues", busy, 1);
    chk("R3 no half in reload", half_flag, 0);
    chk("R4 no irq in reload", irq, 0);
    reg_wr(2'd1, CW'(5'b10110));
    chk("R7 disabled no phase", {rd_req, wr_req}, 0);
    chk("R7 active-high inactive", ack, 0);

    summary();
  end
endmodule